// File: doc/BRIEF.md
# Serial Command Receiver with In-Band Frame Reset

This block takes commands from a controller over two wires, a serial clock and a serial data line, and returns diagnostic status on a third wire. No select line exists. The controller marks the start of each frame by raising the data line while the serial clock is already high. That framing reset clears the bit counter, so a receiver that has fallen out of step after a glitch is back in phase at the next frame.

After the framing reset ends, the first eight rising serial-clock edges shift in a command, least significant bit first. The command becomes active only when the eighth bit arrives. The active command drives a two-bit amplifier gain select and a test-output select. The next three clock periods send three diagnostic inputs back to the controller on the data output, one bit per period. Each bit changes on a falling serial-clock edge. When the test-output select is set, the data output instead carries an external carrier divided by 32.

All serial inputs are sampled in a faster system clock domain through synchronizer stages, and all edge detection is done in that domain.

Top module: `serial_cmd_rx`

## Requirements
- R1: Asynchronous reset (rst_ni low) clears the active command to 0x00 and drives sdo_o low. It also leaves the bit counter idle, so serial clock pulses have no effect until the first framing reset.
- R2: A framing reset starts when sdi_i rises while sclk_i is high. A rise of sdi_i while sclk_i is low is a normal data change and does not restart the frame.
- R3: The framing reset lasts as long as sclk_i and sdi_i are both high. It ends when either one falls, in either order. The first rising sclk_i edge after it ends samples command bit 0.
- R4: Command bits are sampled on rising sclk_i edges, bit 0 first. cmd_o keeps its old value through the first seven bits and takes the new 8-bit value on the eighth.
- R5: gain_o equals command bits [7:6], and test_sel_o equals command bit 3.
- R6: With test select off, sdo_o takes diag_i[0], diag_i[1] and diag_i[2] on the falling sclk_i edges after rising edges 8, 9 and 10 of the frame. It returns low on the falling edge after rising edge 11, and it is low outside this window.
- R7: Rising sclk_i edges after the eleventh in a frame are ignored until the next framing reset: cmd_o and sdo_o do not change.
- R8: A frame cut short by a new framing reset before its eighth bit leaves cmd_o unchanged. The new frame then receives a command normally.
- R9: With test select on, sdo_o is carrier_i divided by 32. Starting low after reset, it toggles on every 16th rising edge of carrier_i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock used to sample all serial inputs |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the controller |
| sdi_i | input | 1 | Serial data and framing line from the controller |
| carrier_i | input | 1 | Carrier to be divided for the test output |
| diag_i | input | 3 | Diagnostic status bits returned in the output phase |
| sdo_o | output | 1 | Serial diagnostic output, or the divided carrier in test mode |
| cmd_o | output | 8 | Active command register |
| gain_o | output | 2 | Amplifier gain select |
| test_sel_o | output | 1 | Test-output select |

## Verification
The bench checks cmd_o after the seventh bit and again after the eighth. A design that commits early, or that shifts bits in the wrong order, shows the wrong value there. Reset is ended both ways, with the clock falling first and with the data falling first. A design that counts the clock's own falling edge, or its rise at the end of a reset, misaligns the whole command. The bench also drives a data rise while the clock is low in the middle of a frame, and a frame aborted after five bits. A receiver that resets on any data edge, or commits a partial shift register, corrupts cmd_o in those cases. Extra clocks after the eleventh and an exact count of 16 carrier edges expose a counter that wraps, or a divider that is off by one.

// File: rtl/cmdrx_pkg.sv
package cmdrx_pkg;
  localparam int unsigned CMD_W     = 8;
  localparam int unsigned DIAG_W    = 3;
  localparam int unsigned FRAME_LEN = CMD_W + DIAG_W;
  localparam int unsigned CNT_W     = $clog2(FRAME_LEN + 1);
  localparam int unsigned GAIN_LSB  = 6;
  localparam int unsigned GAIN_W    = 2;
  localparam int unsigned TEST_BIT  = 3;

  typedef logic [CNT_W-1:0] bitcnt_t;
  typedef logic [CMD_W-1:0] cmd_t;
endpackage

// File: rtl/cmdrx_sync.sv
module cmdrx_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  logic [WIDTH-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg_q[0] <= '0;
    else         stg_q[0] <= d_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else         stg_q[s] <= stg_q[s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/cmdrx_frame.sv
module cmdrx_frame
  import cmdrx_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    sclk_i,
  input  logic    sdi_i,
  output logic    sclk_fall_o,
  output logic    frm_rst_o,
  output bitcnt_t cnt_o,
  output cmd_t    cmd_o
);
  localparam bitcnt_t IDLE_CNT = bitcnt_t'(FRAME_LEN);
  localparam bitcnt_t LAST_CMD = bitcnt_t'(CMD_W - 1);

  logic    sclk_q, sdi_q, hold_q;
  logic    sclk_rise, sdi_rise, frm_rst;
  bitcnt_t cnt_q;
  cmd_t    shf_q, cmd_q;

  assign sclk_rise   = sclk_i & ~sclk_q;
  assign sclk_fall_o = ~sclk_i & sclk_q;
  assign sdi_rise    = sdi_i & ~sdi_q;
  // framing reset: entered by a data rise under a high clock, held while both stay high
  assign frm_rst     = (sdi_rise & sclk_i) | (hold_q & sclk_i & sdi_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sclk_q <= 1'b0;
      sdi_q  <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      sclk_q <= sclk_i;
      sdi_q  <= sdi_i;
      hold_q <= frm_rst;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= IDLE_CNT;
      shf_q <= '0;
      cmd_q <= '0;
    end else if (frm_rst) begin
      cnt_q <= '0;
      shf_q <= '0;
    end else if (sclk_rise && cnt_q < IDLE_CNT) begin
      cnt_q <= cnt_q + 1'b1;
      if (cnt_q < bitcnt_t'(CMD_W)) shf_q <= {sdi_i, shf_q[CMD_W-1:1]};
      if (cnt_q == LAST_CMD)        cmd_q <= {sdi_i, shf_q[CMD_W-1:1]};
    end
  end

  assign frm_rst_o = frm_rst;
  assign cnt_o     = cnt_q;
  assign cmd_o     = cmd_q;
endmodule

// File: rtl/cmdrx_diag_tx.sv
module cmdrx_diag_tx
  import cmdrx_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_fall_i,
  input  logic              frm_rst_i,
  input  bitcnt_t           cnt_i,
  input  logic [DIAG_W-1:0] diag_i,
  output logic              sdo_o
);
  logic sel_bit, sdo_q;

  always_comb begin
    sel_bit = 1'b0;
    for (int i = 0; i < DIAG_W; i++) begin
      if (cnt_i == bitcnt_t'(CMD_W + i)) sel_bit = diag_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          sdo_q <= 1'b0;
    else if (frm_rst_i)   sdo_q <= 1'b0;
    else if (sclk_fall_i) sdo_q <= sel_bit;
  end

  assign sdo_o = sdo_q;
endmodule

// File: rtl/cmdrx_clkdiv.sv
module cmdrx_clkdiv #(
  parameter int unsigned DIV_LOG2 = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic carrier_i,
  output logic div_o
);
  localparam int unsigned HALF_W = DIV_LOG2 - 1;

  logic              car_q, div_q;
  logic [HALF_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      car_q <= 1'b0;
      div_q <= 1'b0;
      cnt_q <= '0;
    end else begin
      car_q <= carrier_i;
      if (carrier_i && !car_q) begin
        cnt_q <= cnt_q + 1'b1;
        if (&cnt_q) div_q <= ~div_q;
      end
    end
  end

  assign div_o = div_q;
endmodule

// File: rtl/serial_cmd_rx.sv
module serial_cmd_rx
  import cmdrx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned DIV_LOG2    = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sclk_i,
  input  logic              sdi_i,
  input  logic              carrier_i,
  input  logic [DIAG_W-1:0] diag_i,
  output logic              sdo_o,
  output logic [CMD_W-1:0]  cmd_o,
  output logic [GAIN_W-1:0] gain_o,
  output logic              test_sel_o
);
  logic [2:0] raw_in, syn_in;
  logic       sclk_s, sdi_s, car_s;
  logic       sclk_fall, frm_rst, diag_sdo, div_out;
  bitcnt_t    bit_cnt;
  cmd_t       cmd;

  assign raw_in = {carrier_i, sdi_i, sclk_i};
  assign {car_s, sdi_s, sclk_s} = syn_in;

  cmdrx_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (raw_in),
    .q_o   (syn_in)
  );

  cmdrx_frame u_frame (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_i     (sclk_s),
    .sdi_i      (sdi_s),
    .sclk_fall_o(sclk_fall),
    .frm_rst_o  (frm_rst),
    .cnt_o      (bit_cnt),
    .cmd_o      (cmd)
  );

  cmdrx_diag_tx u_diag (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sclk_fall_i(sclk_fall),
    .frm_rst_i  (frm_rst),
    .cnt_i      (bit_cnt),
    .diag_i     (diag_i),
    .sdo_o      (diag_sdo)
  );

  cmdrx_clkdiv #(.DIV_LOG2(DIV_LOG2)) u_div (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .carrier_i(car_s),
    .div_o    (div_out)
  );

  assign cmd_o      = cmd;
  assign gain_o     = cmd[GAIN_LSB +: GAIN_W];
  assign test_sel_o = cmd[TEST_BIT];
  assign sdo_o      = test_sel_o ? div_out : diag_sdo;
endmodule

// File: rtl/serial_cmd_rx_chk.sv
module serial_cmd_rx_chk
  import cmdrx_pkg::*;
(
  input logic    clk_i,
  input logic    rst_ni,
  input logic    frm_rst_i,
  input bitcnt_t cnt_i,
  input cmd_t    cmd_i,
  input logic    sdo_i,
  input logic    test_sel_i
);
  p_frame_clear_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_rst_i |=> cnt_i == '0);

  p_commit_on_eighth_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(cmd_i) |-> $past(cnt_i) == bitcnt_t'(CMD_W - 1));

  p_diag_window_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sdo_i && !test_sel_i) |-> cnt_i >= bitcnt_t'(CMD_W));

  p_count_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_i <= bitcnt_t'(FRAME_LEN));

  p_count_parked_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == bitcnt_t'(FRAME_LEN) && !frm_rst_i) |=> cnt_i == bitcnt_t'(FRAME_LEN));

  p_abort_keeps_cmd_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frm_rst_i |=> $stable(cmd_i));
endmodule

bind serial_cmd_rx serial_cmd_rx_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .frm_rst_i (frm_rst),
  .cnt_i     (bit_cnt),
  .cmd_i     (cmd_o),
  .sdo_i     (sdo_o),
  .test_sel_i(test_sel_o)
);

// File: tb/serial_cmd_rx_tb_top.sv
module serial_cmd_rx_tb_top;
  localparam int SETTLE = 8;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       sclk_i = 1'b0, sdi_i = 1'b0, carrier_i = 1'b0;
  logic [2:0] diag_i = 3'b000;
  logic       sdo_o, test_sel_o;
  logic [7:0] cmd_o;
  logic [1:0] gain_o;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  typedef struct { string req; logic [7:0] val; } exp_t;
  exp_t exp_q[$];

  always #2.5 clk_i = ~clk_i;

  serial_cmd_rx dut_i (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_i(sclk_i), .sdi_i(sdi_i),
    .carrier_i(carrier_i), .diag_i(diag_i), .sdo_o(sdo_o), .cmd_o(cmd_o),
    .gain_o(gain_o), .test_sel_o(test_sel_o)
  );

  // driver side: record the expectation
  task automatic expect_val(string req, logic [7:0] v);
    exp_t e;
    e.req = req; e.val = v;
    exp_q.push_back(e);
  endtask

  // monitor side: pop the oldest expectation and compare
  task automatic observe(logic [7:0] act);
    exp_t e;
    e = exp_q.pop_front();
    n_vec++;
    if (act !== e.val) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", e.req, act, e.val);
    end
  endtask

  task automatic drive(logic c, logic d);
    @(negedge clk_i);
    sclk_i = c; sdi_i = d;
    repeat (SETTLE) @(negedge clk_i);
  endtask

  task automatic frame_reset(bit data_first);
    drive(0, 0); drive(1, 0); drive(1, 1);
    if (data_first) begin drive(1, 0); drive(0, 0); end
    else            begin drive(0, 1); end
  endtask

  task automatic send_bit(logic b);
    drive(0, b); drive(1, b); drive(0, b);
  endtask

  task automatic send_bits(logic [7:0] v, int n);
    for (int i = 0; i < n; i++) send_bit(v[i]);
  endtask

  task automatic pulse();
    drive(1, 1); drive(0, 1);
  endtask

  task automatic carrier_edges(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i); carrier_i = 1'b1;
      repeat (4) @(negedge clk_i); carrier_i = 1'b0;
      repeat (4) @(negedge clk_i);
    end
    repeat (SETTLE) @(negedge clk_i);
  endtask

  initial begin
    int cyc = 0;
    while (!done) begin
      @(posedge clk_i);
      cyc++;
      if (cyc > 150000) begin
        n_bad++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
      end
    end
  end

  initial begin
    repeat (5) @(negedge clk_i);
    // R1: reset state
    expect_val("R1 cmd after reset", 8'h00); observe(cmd_o);
    expect_val("R1 sdo after reset", 8'h00); observe({7'b0, sdo_o});
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    // R1: clock pulses before any framing reset are ignored
    send_bits(8'hFF, 8);
    expect_val("R1 idle counter ignores clocks", 8'h00); observe(cmd_o);

    // R4/R5/R6: full frame, reset ended by clock falling first
    diag_i = 3'b101;
    frame_reset(0);
    send_bits(8'hA5, 7);
    expect_val("R4 cmd held through bit 7", 8'h00); observe(cmd_o);
    send_bit(1'b1);
    expect_val("R4 cmd after bit 8", 8'hA5); observe(cmd_o);
    expect_val("R5 gain from bits 7:6", 8'h02); observe({6'b0, gain_o});
    expect_val("R5 test select bit 3", 8'h00); observe({7'b0, test_sel_o});
    expect_val("R6 diag bit 0", 8'h01); observe({7'b0, sdo_o});
    pulse();
    expect_val("R6 diag bit 1", 8'h00); observe({7'b0, sdo_o});
    pulse();
    expect_val("R6 diag bit 2", 8'h01); observe({7'b0, sdo_o});
    pulse();
    expect_val("R6 sdo low after window", 8'h00); observe({7'b0, sdo_o});
    // R7: extra clocks ignored
    diag_i = 3'b111;
    pulse(); pulse();
    expect_val("R7 cmd unchanged by extra clocks", 8'hA5); observe(cmd_o);
    expect_val("R7 sdo low on extra clocks", 8'h00); observe({7'b0, sdo_o});

    // R3: reset ended by data falling first; R4 bit order check
    frame_reset(1);
    send_bits(8'h01, 8);
    expect_val("R3 data-first reset end, bit 0 aligned", 8'h01); observe(cmd_o);
    expect_val("R5 gain zero", 8'h00); observe({6'b0, gain_o});

    // R8: aborted frame, then resync
    frame_reset(0);
    send_bits(8'hFF, 5);
    frame_reset(0);
    expect_val("R8 aborted frame keeps cmd", 8'h01); observe(cmd_o);
    send_bits(8'h3C, 8);
    expect_val("R8 resync after abort", 8'h3C); observe(cmd_o);

    // R2: data rise with clock low mid-frame is not a reset
    frame_reset(0);
    send_bits(8'hC2, 4);
    drive(0, 0); drive(0, 1); drive(0, 0);
    send_bits(8'hC2 >> 4, 4);
    expect_val("R2 low-clock data rise ignored", 8'hC2); observe(cmd_o);
    expect_val("R5 gain 3", 8'h03); observe({6'b0, gain_o});

    // R9: test output divides carrier by 32
    frame_reset(0);
    send_bits(8'h48, 8);
    expect_val("R5 test select set", 8'h01); observe({7'b0, test_sel_o});
    expect_val("R5 gain 1", 8'h01); observe({6'b0, gain_o});
    expect_val("R9 divider starts low", 8'h00); observe({7'b0, sdo_o});
    carrier_edges(15);
    expect_val("R9 low after 15 edges", 8'h00); observe({7'b0, sdo_o});
    carrier_edges(1);
    expect_val("R9 high after 16 edges", 8'h01); observe({7'b0, sdo_o});
    carrier_edges(16);
    expect_val("R9 low after 32 edges", 8'h00); observe({7'b0, sdo_o});
    carrier_edges(16);
    expect_val("R9 high after 48 edges", 8'h01); observe({7'b0, sdo_o});

    // R6: test off returns sdo to diagnostic path
    diag_i = 3'b000;
    frame_reset(0);
    send_bits(8'h00, 8);
    expect_val("R6 sdo low with test off", 8'h00); observe({7'b0, sdo_o});

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule